// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block is the sequencing core of an instruction fetch stage. It keeps a 21-bit program counter, a 16-entry return address stack and the instruction register that, together with the counter, forms a two-stage fetch/execute pipeline. While one word is being fetched at the current program counter, the instruction register holds the previous word for the decoder.

Each clock, the decoder drives three opcode fields. The first selects how the program counter moves: increment, hold, relative jump with a short or long signed offset, absolute load, return, or one of two interrupt vectors. The second moves the stack pointer: keep, push or pop. The third either latches the fetched word into the instruction register or forces a NOP into it to flush the pipeline. A push stores the address after the current program counter, so a call is a push combined with an absolute or relative load in the same cycle.

All pins are plain control and data pins with no handshake. The block never applies back-pressure. The decoder stalls the front end with the hold opcode and flushes it with the NOP opcode.

Top module: `pcs_seq_core`

## Requirements
- R1: While `rst_n` is low, asynchronously, `pc` is 0, `ir` is 0, the stack is empty and `stk_err` is 0.
- R2: `pc_op` 0 (next) sets `pc` to `pc`+1 modulo 2^21, and `pc_op` 5 (hold) leaves `pc` unchanged.
- R3: `pc_op` 1 adds `rel_short`, sign-extended from 8 bits, to the current `pc` modulo 2^21.
- R4: `pc_op` 2 adds `rel_long`, sign-extended from 11 bits, to the current `pc` modulo 2^21.
- R5: `pc_op` 3 loads `abs_target` into `pc`.
- R6: `pc_op` 6 loads 0x08 into `pc`, and `pc_op` 7 loads 0x18.
- R7: `stk_op` 1 (push) on a non-full stack grows the stack by one and writes the current `pc`+1 as the new top. `pc_op` 4 (return) loads the top entry into `pc`, or 0 when the stack is empty.
- R8: `stk_op` 2 (pop) on a non-empty stack removes the top entry. Entries come back in last-in first-out order. `stk_op` 0 and 3 leave the stack unchanged.
- R9: A push on a full stack or a pop on an empty stack sets `stk_err`. The stack pointer does not wrap and no entry is changed.
- R10: `stk_err` stays at 1 until reset.
- R11: `ir_op` 0 latches `fetch_word` into `ir` at the clock edge, and `ir_op` 1 loads 0 (NOP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_op | input | 3 | Program counter update code |
| stk_op | input | 2 | Stack pointer code: 0 keep, 1 push, 2 pop, 3 keep |
| ir_op | input | 1 | 0 latch fetched word, 1 force NOP |
| rel_short | input | 8 | Signed short relative offset |
| rel_long | input | 11 | Signed long relative offset |
| abs_target | input | 21 | Absolute jump target |
| fetch_word | input | 16 | Instruction word fetched at `pc` |
| pc | output | 21 | Program counter |
| ir | output | 16 | Instruction register |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench targets the edges of the counter arithmetic: a next from 0x1FFFFF and a negative short offset from 0 must both wrap, and the most negative offsets of each width must extend their sign. A design that zero-extends would jump forward, and one with a narrower adder would lose the top bits. For the stack, the bench fills all sixteen entries and then pushes once more. The sixteen returns that follow must come back in reverse order with the original top intact, so a pointer that wraps or a write that lands on overflow returns a wrong address. It also pops an empty stack, checks that the error flag stays set through later cycles, and checks that only reset clears it. A long random run mixing all opcodes then compares every cycle against a behavioural model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    PC_NEXT   = 3'd0,
    PC_REL_S  = 3'd1,
    PC_REL_L  = 3'd2,
    PC_ABS    = 3'd3,
    PC_RET    = 3'd4,
    PC_HOLD   = 3'd5,
    PC_VEC_HI = 3'd6,
    PC_VEC_LO = 3'd7
  } pc_op_e;

  typedef enum logic [1:0] {
    STK_KEEP = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_RSVD = 2'd3
  } stk_op_e;

  typedef enum logic {
    IR_LATCH = 1'b0,
    IR_FLUSH = 1'b1
  } ir_op_e;

endpackage

// File: rtl/pcs_next_pc.sv
module pcs_next_pc #(
  parameter int PC_W    = 21,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 11,
  parameter int VEC_HI  = 8,
  parameter int VEC_LO  = 24
) (
  input  pcs_pkg::pc_op_e    op,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic [SHORT_W-1:0] off_s,
  input  logic [LONG_W-1:0]  off_l,
  input  logic [PC_W-1:0]    target,
  input  logic [PC_W-1:0]    tos,
  output logic [PC_W-1:0]    nxt_pc,
  output logic [PC_W-1:0]    ret_addr
);
  import pcs_pkg::*;

  localparam int EXT_S = PC_W - SHORT_W;
  localparam int EXT_L = PC_W - LONG_W;
  localparam logic [PC_W-1:0] HI_ADDR = PC_W'(VEC_HI);
  localparam logic [PC_W-1:0] LO_ADDR = PC_W'(VEC_LO);

  logic [PC_W-1:0] sext_s;
  logic [PC_W-1:0] sext_l;

  assign sext_s   = {{EXT_S{off_s[SHORT_W-1]}}, off_s};
  assign sext_l   = {{EXT_L{off_l[LONG_W-1]}}, off_l};
  assign ret_addr = cur_pc + PC_W'(1);

  always_comb begin
    unique case (op)
      PC_NEXT:   nxt_pc = ret_addr;
      PC_REL_S:  nxt_pc = cur_pc + sext_s;
      PC_REL_L:  nxt_pc = cur_pc + sext_l;
      PC_ABS:    nxt_pc = target;
      PC_RET:    nxt_pc = tos;
      PC_HOLD:   nxt_pc = cur_pc;
      PC_VEC_HI: nxt_pc = HI_ADDR;
      PC_VEC_LO: nxt_pc = LO_ADDR;
      default:   nxt_pc = cur_pc;
    endcase
  end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 21,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pcs_pkg::stk_op_e op,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     tos,
  output logic [CW-1:0]    depth,
  output logic             err
);
  import pcs_pkg::*;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic            is_full;
  logic            is_empty;
  logic            do_push;
  logic            do_pop;
  logic            fault;
  logic [W-1:0]    cells [DEPTH];

  assign is_full  = (depth == FULL_CNT);
  assign is_empty = (depth == '0);
  assign do_push  = (op == STK_PUSH) && !is_full;
  assign do_pop   = (op == STK_POP) && !is_empty;
  assign fault    = ((op == STK_PUSH) && is_full) || ((op == STK_POP) && is_empty);

  // Push: pointer grows, new top receives the data (pre-increment).
  // Pop: top is read combinationally, then pointer shrinks.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (do_push && depth == CW'(g)) q <= wdata;
    end
    assign cells[g] = q;
  end

  always_comb begin
    tos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth == CW'(i + 1)) tos = cells[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      err   <= 1'b0;
    end else begin
      if (do_push)     depth <= depth + CW'(1);
      else if (do_pop) depth <= depth - CW'(1);
      if (fault) err <= 1'b1;
    end
  end

endmodule

// File: rtl/pcs_instr_reg.sv
module pcs_instr_reg #(
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pcs_pkg::ir_op_e op,
  input  logic [IW-1:0]   word,
  output logic [IW-1:0]   q
);
  import pcs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (op == IR_FLUSH)   q <= '0;
    else                       q <= word;
  end

endmodule

// File: rtl/pcs_seq_core.sv
module pcs_seq_core #(
  parameter int PC_W    = 21,
  parameter int IW      = 16,
  parameter int DEPTH   = 16,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 11,
  parameter int VEC_HI  = 8,
  parameter int VEC_LO  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         pc_op,
  input  logic [1:0]         stk_op,
  input  logic               ir_op,
  input  logic [SHORT_W-1:0] rel_short,
  input  logic [LONG_W-1:0]  rel_long,
  input  logic [PC_W-1:0]    abs_target,
  input  logic [IW-1:0]      fetch_word,
  output logic [PC_W-1:0]    pc,
  output logic [IW-1:0]      ir,
  output logic               stk_err
);
  import pcs_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  pc_op_e          pc_code;
  stk_op_e         stk_code;
  ir_op_e          ir_code;
  logic [PC_W-1:0] nxt_pc;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] top_entry;
  logic [CW-1:0]   stk_depth;

  assign pc_code  = pc_op_e'(pc_op);
  assign stk_code = stk_op_e'(stk_op);
  assign ir_code  = ir_op_e'(ir_op);

  pcs_next_pc #(
    .PC_W(PC_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W),
    .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
  ) u_next (
    .op(pc_code), .cur_pc(pc), .off_s(rel_short), .off_l(rel_long),
    .target(abs_target), .tos(top_entry), .nxt_pc(nxt_pc), .ret_addr(ret_addr)
  );

  pcs_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .op(stk_code), .wdata(ret_addr),
    .tos(top_entry), .depth(stk_depth), .err(stk_err)
  );

  pcs_instr_reg #(.IW(IW)) u_ir (
    .clk(clk), .rst_n(rst_n), .op(ir_code), .word(fetch_word), .q(ir)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= nxt_pc;
  end

endmodule

// File: rtl/pcs_seq_core_chk.sv
module pcs_seq_core_chk #(
  parameter int PC_W  = 21,
  parameter int IW    = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      pc_op,
  input logic [1:0]      stk_op,
  input logic            ir_op,
  input logic [PC_W-1:0] abs_target,
  input logic [PC_W-1:0] pc,
  input logic [IW-1:0]   ir,
  input logic            stk_err,
  input logic [CW-1:0]   depth
);

  a_r2_next_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'd0 |=> pc == $past(pc) + PC_W'(1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'd5 |=> $stable(pc));

  a_r5_abs_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'd3 |=> pc == $past(abs_target));

  a_r6_vec_hi: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'd6 |=> pc == PC_W'(8));

  a_r6_vec_lo: assert property (@(posedge clk) disable iff (!rst_n)
    pc_op == 3'd7 |=> pc == PC_W'(24));

  a_r9_no_wrap_full: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op == 2'd1 && depth == CW'(DEPTH)) |=> (stk_err && depth == CW'(DEPTH)));

  a_r9_no_wrap_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op == 2'd2 && depth == '0) |=> (stk_err && depth == '0));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ir_op |=> ir == '0);

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

endmodule

bind pcs_seq_core pcs_seq_core_chk #(
  .PC_W(PC_W), .IW(IW), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_op(pc_op), .stk_op(stk_op), .ir_op(ir_op),
  .abs_target(abs_target), .pc(pc), .ir(ir), .stk_err(stk_err), .depth(stk_depth)
);

// File: tb/pcs_seq_core_tb_top.sv
module pcs_seq_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pc_op = '0;
  logic [1:0]  stk_op = '0;
  logic        ir_op = 1'b0;
  logic [7:0]  rel_short = '0;
  logic [10:0] rel_long = '0;
  logic [20:0] abs_target = '0;
  logic [15:0] fetch_word = '0;
  logic [20:0] pc;
  logic [15:0] ir;
  logic        stk_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [20:0] m_pc;
  logic [15:0] m_ir;
  logic [20:0] m_stk [16];
  int          m_depth;
  bit          m_err;

  always #10 clk = ~clk;

  pcs_seq_core dut_i (
    .clk(clk), .rst_n(rst_n), .pc_op(pc_op), .stk_op(stk_op), .ir_op(ir_op),
    .rel_short(rel_short), .rel_long(rel_long), .abs_target(abs_target),
    .fetch_word(fetch_word), .pc(pc), .ir(ir), .stk_err(stk_err)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "pc", 32'(pc), 32'(m_pc));
    chk(tag, "ir", 32'(ir), 32'(m_ir));
    chk(tag, "stk_err", 32'(stk_err), 32'(m_err));
  endtask

  task automatic model_reset();
    m_pc = '0; m_ir = '0; m_depth = 0; m_err = 0;
  endtask

  // One clock: drive at the falling edge, advance the model, compare at the next falling edge.
  task automatic step(string tag, logic [2:0] op, logic [1:0] so, logic io,
                      logic [7:0] o8, logic [10:0] o11, logic [20:0] tgt, logic [15:0] w);
    logic [20:0] tos;
    logic [20:0] n;
    pc_op = op; stk_op = so; ir_op = io; rel_short = o8; rel_long = o11;
    abs_target = tgt; fetch_word = w;
    tos = (m_depth > 0) ? m_stk[m_depth-1] : 21'd0;
    case (op)
      3'd0: n = m_pc + 21'd1;
      3'd1: n = m_pc + {{13{o8[7]}}, o8};
      3'd2: n = m_pc + {{10{o11[10]}}, o11};
      3'd3: n = tgt;
      3'd4: n = tos;
      3'd5: n = m_pc;
      3'd6: n = 21'h08;
      default: n = 21'h18;
    endcase
    if (so == 2'd1) begin
      if (m_depth == 16) m_err = 1;
      else begin m_stk[m_depth] = m_pc + 21'd1; m_depth++; end
    end else if (so == 2'd2) begin
      if (m_depth == 0) m_err = 1;
      else m_depth--;
    end
    m_pc = n;
    m_ir = io ? 16'h0 : w;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
  endtask

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0, 3'd5: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R11: latch and flush
    step("R11", 3'd0, 2'd0, 1'b0, 0, 0, 0, 16'hA5A5);
    step("R11", 3'd0, 2'd0, 1'b0, 0, 0, 0, 16'h1234);
    step("R11", 3'd0, 2'd0, 1'b1, 0, 0, 0, 16'hFFFF);
    step("R2", 3'd5, 2'd0, 1'b0, 0, 0, 0, 16'h0F0F);
    step("R2", 3'd5, 2'd3, 1'b0, 0, 0, 0, 16'h0F0E);
    step("R3", 3'd1, 2'd0, 1'b0, 8'h05, 0, 0, 16'h1);
    step("R3", 3'd1, 2'd0, 1'b0, 8'h80, 0, 0, 16'h2);
    step("R4", 3'd2, 2'd0, 1'b0, 0, 11'h400, 0, 16'h3);
    step("R4", 3'd2, 2'd0, 1'b0, 0, 11'h3FF, 0, 16'h4);
    step("R5", 3'd3, 2'd0, 1'b0, 0, 0, 21'h1FFFFF, 16'h5);
    step("R2", 3'd0, 2'd0, 1'b0, 0, 0, 0, 16'h6);
    step("R3", 3'd1, 2'd0, 1'b0, 8'hFF, 0, 0, 16'h7);
    step("R6", 3'd6, 2'd0, 1'b0, 0, 0, 0, 16'h8);
    step("R6", 3'd7, 2'd0, 1'b0, 0, 0, 0, 16'h9);
    // R7: sixteen nested calls
    for (int i = 0; i < 16; i++)
      step("R7", 3'd3, 2'd1, 1'b0, 0, 0, 21'(i * 21'h1111 + 21'h40), 16'(i));
    // R8: sixteen returns in LIFO order
    for (int i = 0; i < 16; i++)
      step("R8", 3'd4, 2'd2, 1'b1, 0, 0, 0, 16'hBEEF);
    // R9: pop on empty, R10: flag persists
    step("R9", 3'd4, 2'd2, 1'b0, 0, 0, 0, 16'h11);
    for (int i = 0; i < 4; i++)
      step("R10", 3'd0, 2'd0, 1'b0, 0, 0, 0, 16'(i));
    do_reset();
    for (int i = 0; i < 16; i++)
      step("R7", 3'd2, 2'd1, 1'b0, 0, 11'(i * 7 + 3), 0, 16'(i));
    step("R9", 3'd3, 2'd1, 1'b0, 0, 0, 21'h0ABCDE, 16'h22);
    for (int i = 0; i < 16; i++)
      step("R9", 3'd4, 2'd2, 1'b0, 0, 0, 0, 16'h33);
    do_reset();
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [1:0] so;
      op = 3'($urandom_range(0, 7));
      so = 2'($urandom_range(0, 3));
      if (i % 500 == 0 && i > 0) do_reset();
      step(tag_of(op), op, so, 1'($urandom_range(0, 1)), 8'($urandom),
           11'($urandom), 21'($urandom), 16'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule